// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps a 24-bit time-of-day count that advances by one on each pulse of an external tick input, such as a line or frame sync. Software reaches the count through three byte-wide locations: low, medium and high. A select input chooses whether a write lands in the counter or in a 24-bit alarm register. The alarm register is written only; it is never read back.

The write order controls counting. Writing the high byte halts the counter, so software can load a new time without the count moving partway through the load. Writing the low byte restarts it. Reading the high byte takes a snapshot of the whole count. The medium and low reads then come from that snapshot, so a read of all three bytes gives a consistent value. The low read releases the snapshot.

A match between the count and the alarm produces a one-cycle pulse for an interrupt unit. A match is tested only when the count changes by a tick or by a low-byte write. The match test also covers a short carry glitch in the medium byte: the count can briefly show the old upper bits with zeros below bit 12, and an alarm equal to that glitch value also produces a pulse.

Top module: `tod_clock`

## Requirements
- R1: After reset the count is 0x000000, the counter is halted, no snapshot is held, the alarm is 0x000000 and `alarm_o` is low.
- R2: While running, each cycle with `tick_i` high and no counter write increments the count by one, wrapping from 0xFFFFFF to 0x000000.
- R3: A write with `alarm_sel_i`=1 updates the alarm byte selected by `sel_i` (0 low, 1 medium, 2 high) and leaves the count unchanged.
- R4: A counter write to the high byte (`sel_i`=2) loads that byte and halts the counter, so later ticks leave the count unchanged.
- R5: A counter write to the low byte (`sel_i`=0) loads that byte and starts the counter. A write to the medium byte (`sel_i`=1) changes only that byte and keeps the running state. A counter write takes priority over a tick in the same cycle.
- R6: A read of the high byte with no snapshot held captures the whole count. While a snapshot is held, medium and low reads return snapshot bytes. A low read releases the snapshot.
- R7: A high read while a snapshot is already held does not capture the count again.
- R8: With no snapshot held, the low and medium reads return the live count. `rdata_o` is combinational on `sel_i`, and `sel_i`=3 reads 0x00.
- R9: When an increment makes the count equal to the alarm, `alarm_o` is high for exactly the cycle after that clock edge.
- R10: A counter low-byte write that leaves the count equal to the alarm pulses `alarm_o` in the same way.
- R11: When an increment produces a count whose low 12 bits are zero, and the previous count with its low 12 bits cleared equals the alarm, `alarm_o` pulses.
- R12: `alarm_o` never pulses without a preceding increment or counter low-byte write. An equal count held while halted, or after a medium or high write, gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count advance request, one per cycle |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe (triggers snapshot side effects) |
| sel_i | input | 2 | Byte select: 0 low, 1 medium, 2 high |
| alarm_sel_i | input | 1 | 1 directs writes to the alarm, 0 to the counter |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected byte |
| alarm_o | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong count or a wrong running flag shows on the next read of any byte. Such an error also moves or removes the alarm pulse within one tick of the expected match. A corrupted alarm register cannot be read, so it shows only as a missing or misplaced pulse when the count reaches the alarm. Sweeps across the 0x1000 carry boundary check that case. A snapshot held or released at the wrong time shows as a mismatch between the medium and low reads that follow a high read taken while ticks run.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int TOD_BYTE_W    = 8;
  localparam int TOD_N_BYTES   = 3;
  localparam int TOD_CARRY_LSB = 12;
  localparam int TOD_CNT_W     = TOD_BYTE_W * TOD_N_BYTES;
endpackage

// File: rtl/tod_counter.sv
`timescale 1ns/1ps
module tod_counter #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  localparam int CNT_W  = BYTE_W * N_BYTES,
  localparam int SEL_W  = $clog2(N_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              run_o,
  output logic              inc_o,
  output logic              lwr_o
);
  logic [CNT_W-1:0] count_q;
  logic run_q, inc_q, lwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
      inc_q   <= 1'b0;
      lwr_q   <= 1'b0;
    end else begin
      inc_q <= 1'b0;
      lwr_q <= 1'b0;
      if (wr_i) begin
        for (int b = 0; b < N_BYTES; b++)
          if (wsel_i == SEL_W'(b)) count_q[b*BYTE_W +: BYTE_W] <= wdata_i;
        if (wsel_i == SEL_W'(0)) begin
          run_q <= 1'b1;
          lwr_q <= 1'b1;
        end
        if (wsel_i == SEL_W'(N_BYTES-1)) run_q <= 1'b0;
      end else if (tick_i && run_q) begin
        count_q <= count_q + CNT_W'(1);
        inc_q   <= 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign run_o   = run_q;
  assign inc_o   = inc_q;
  assign lwr_o   = lwr_q;

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !wr_i) |=> count_q == $past(count_q) + CNT_W'(1));
  a_r4_halted_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !wr_i) |=> $stable(count_q));
endmodule

// File: rtl/tod_snapshot.sv
`timescale 1ns/1ps
module tod_snapshot #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  localparam int CNT_W  = BYTE_W * N_BYTES,
  localparam int SEL_W  = $clog2(N_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [SEL_W-1:0]  rsel_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic             held_q;
  logic [CNT_W-1:0] snap_q;
  logic [CNT_W-1:0] src;
  logic rd_hi, rd_lo;

  assign rd_hi = rd_i && (rsel_i == SEL_W'(N_BYTES-1));
  assign rd_lo = rd_i && (rsel_i == SEL_W'(0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      snap_q <= '0;
    end else if (rd_hi && !held_q) begin
      held_q <= 1'b1;
      snap_q <= count_i;
    end else if (rd_lo && held_q) begin
      held_q <= 1'b0;
    end
  end

  assign src = held_q ? snap_q : count_i;

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < N_BYTES; b++)
      if (rsel_i == SEL_W'(b)) rdata_o = src[b*BYTE_W +: BYTE_W];
  end

  a_r6_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !rd_lo) |=> (held_q && $stable(snap_q)));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && rd_lo) |=> !held_q);
endmodule

// File: rtl/tod_alarm.sv
`timescale 1ns/1ps
module tod_alarm #(
  parameter int BYTE_W    = 8,
  parameter int N_BYTES   = 3,
  parameter int CARRY_LSB = 12,
  localparam int CNT_W    = BYTE_W * N_BYTES,
  localparam int SEL_W    = $clog2(N_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  wsel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              inc_i,
  input  logic              lwr_i,
  output logic              alarm_o
);
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] prev;
  logic eq_hit, carry_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= '0;
    else if (wr_i)
      for (int b = 0; b < N_BYTES; b++)
        if (wsel_i == SEL_W'(b)) alarm_q[b*BYTE_W +: BYTE_W] <= wdata_i;
  end

  // count just moved; the glitch value is the old upper part over zeros
  assign prev      = count_i - CNT_W'(1);
  assign eq_hit    = (inc_i || lwr_i) && (count_i == alarm_q);
  assign carry_hit = inc_i && (count_i[CARRY_LSB-1:0] == '0) &&
                     ({prev[CNT_W-1:CARRY_LSB], CARRY_LSB'(0)} == alarm_q);
  assign alarm_o   = eq_hit || carry_hit;

  a_r3_alarm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(alarm_q));
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int BYTE_W    = TOD_BYTE_W,
  parameter int N_BYTES   = TOD_N_BYTES,
  parameter int CARRY_LSB = TOD_CARRY_LSB
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [$clog2(N_BYTES)-1:0] sel_i,
  input  logic                       alarm_sel_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [BYTE_W-1:0]          rdata_o,
  output logic                       alarm_o
);
  localparam int CNT_W = BYTE_W * N_BYTES;

  logic [CNT_W-1:0] count;
  logic run, inc, lwr;
  logic wr_cnt, wr_alm;

  assign wr_cnt = wr_en_i && !alarm_sel_i;
  assign wr_alm = wr_en_i && alarm_sel_i;

  tod_counter #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .wr_i(wr_cnt), .wsel_i(sel_i), .wdata_i,
    .count_o(count), .run_o(run), .inc_o(inc), .lwr_o(lwr)
  );

  tod_snapshot #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_snap (
    .clk_i, .rst_ni, .rd_i(rd_en_i), .rsel_i(sel_i),
    .count_i(count), .rdata_o
  );

  tod_alarm #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .CARRY_LSB(CARRY_LSB)) u_alm (
    .clk_i, .rst_ni, .wr_i(wr_alm), .wsel_i(sel_i), .wdata_i,
    .count_i(count), .inc_i(inc), .lwr_i(lwr), .alarm_o
  );

  a_r12_alarm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> $past((wr_cnt && sel_i == '0) || (tick_i && run)));
  a_r5_start_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt && sel_i == '0) |=> run);
endmodule

// File: tb/sim_tod_clock.sv
`timescale 1ns/1ps
module sim_tod_clock;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 0, wr_en_i = 0, rd_en_i = 0, alarm_sel_i = 0;
  logic [1:0] sel_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic alarm_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the requirements
  logic [23:0] m_cnt = '0, m_alm = '0, m_snap = '0;
  bit m_run = 0, m_held = 0, m_ev = 0;

  tod_clock u0 (.clk_i(clk), .rst_ni, .tick_i, .wr_en_i, .rd_en_i, .sel_i,
                .alarm_sel_i, .wdata_i, .rdata_o, .alarm_o);

  always #10 clk = ~clk;

  function automatic logic [7:0] byte_at(logic [23:0] v, logic [1:0] s);
    return (s == 2'd3) ? 8'h00 : 8'((v >> (8 * s)) & 24'hFF);
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one cycle; called and returns at a falling edge
  task automatic cyc(input bit tk, input bit wr, input bit rd, input logic [1:0] s,
                     input bit asel, input logic [7:0] wd, input string tag);
    logic [23:0] nxt, prv;
    tick_i = tk; wr_en_i = wr; rd_en_i = rd; sel_i = s; alarm_sel_i = asel; wdata_i = wd;
    #1;
    if (rd) check(24'(rdata_o), 24'(byte_at(m_held ? m_snap : m_cnt, s)), tag);
    @(posedge clk);
    if (rd && s == 2'd2 && !m_held) begin m_held = 1; m_snap = m_cnt; end
    else if (rd && s == 2'd0 && m_held) m_held = 0;
    m_ev = 0;
    if (wr && asel) begin
      if (s != 2'd3) m_alm[8*s +: 8] = wd;
    end
    nxt = m_cnt;
    if (wr && !asel) begin
      if (s != 2'd3) nxt[8*s +: 8] = wd;
      if (s == 2'd0) m_run = 1;
      if (s == 2'd2) m_run = 0;
      m_cnt = nxt;
      if (s == 2'd0) m_ev = (m_cnt == m_alm);
    end else if (tk && m_run) begin
      prv = m_cnt;
      m_cnt = m_cnt + 24'd1;
      m_ev = (m_cnt == m_alm) ||
             (m_cnt[11:0] == 12'h000 && {prv[23:12], 12'h000} == m_alm);
    end
    @(negedge clk);
    check(24'(alarm_o), 24'(m_ev), tag);
  endtask

  task automatic wr_cnt(input logic [23:0] v, input string tag);
    cyc(0, 1, 0, 2'd2, 0, v[23:16], tag);
    cyc(0, 1, 0, 2'd1, 0, v[15:8], tag);
    cyc(0, 1, 0, 2'd0, 0, v[7:0], tag);
  endtask

  task automatic wr_alm(input logic [23:0] v, input string tag);
    cyc(0, 1, 0, 2'd2, 1, v[23:16], tag);
    cyc(0, 1, 0, 2'd1, 1, v[15:8], tag);
    cyc(0, 1, 0, 2'd0, 1, v[7:0], tag);
  endtask

  task automatic rd_all(input string tag);
    cyc(0, 0, 1, 2'd2, 0, 8'h00, tag);
    cyc(0, 0, 1, 2'd1, 0, 8'h00, tag);
    cyc(0, 0, 1, 2'd0, 0, 8'h00, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 2'd0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state, halted, ticks ignored, no pulse though count == alarm
    check(24'(alarm_o), 24'd0, "R1");
    rd_all("R1");
    ticks(5, "R1");
    rd_all("R1");
    cyc(0, 0, 1, 2'd3, 0, 8'h00, "R8");
    // R5: load and start, then count; R2 increments
    wr_cnt(24'h00_00F0, "R5");
    ticks(20, "R2");
    rd_all("R2");
    // R3: alarm writes leave count alone
    wr_alm(24'h00_0105, "R3");
    cyc(0, 0, 1, 2'd0, 0, 8'h00, "R3");
    cyc(0, 0, 1, 2'd1, 0, 8'h00, "R3");
    // R9: reach 0x105 by ticking
    ticks(20, "R9");
    // R9/R11 sweep across the 0x1000 carry boundary, alarm 0 hits the glitch
    for (int a = 0; a < 16; a++) begin
      logic [23:0] av;
      av = (a == 0) ? 24'h00_0000 : 24'h00_0EF0 + 24'(a * 19);
      wr_alm(av, "R9");
      wr_cnt(24'h00_0EF0, "R9");
      ticks(300, "R11");
    end
    // R11: glitch value from a high carry
    wr_alm(24'h12_3000, "R11");
    wr_cnt(24'h12_3FF8, "R11");
    ticks(16, "R11");
    rd_all("R11");
    // R2: wrap
    wr_alm(24'h00_0001, "R2");
    wr_cnt(24'hFF_FFFD, "R2");
    ticks(5, "R2");
    rd_all("R2");
    // R6/R7/R8: snapshot while ticks run
    wr_cnt(24'h00_40FE, "R6");
    cyc(1, 0, 1, 2'd2, 0, 8'h00, "R6");
    ticks(4, "R6");
    cyc(1, 0, 1, 2'd2, 0, 8'h00, "R7");
    ticks(3, "R7");
    cyc(1, 0, 1, 2'd1, 0, 8'h00, "R6");
    cyc(1, 0, 1, 2'd0, 0, 8'h00, "R6");
    cyc(1, 0, 1, 2'd1, 0, 8'h00, "R8");
    cyc(1, 0, 1, 2'd0, 0, 8'h00, "R8");
    // R4: high write halts
    cyc(0, 1, 0, 2'd2, 0, 8'h07, "R4");
    ticks(6, "R4");
    rd_all("R4");
    // R5: medium write keeps halted; write beats tick
    cyc(1, 1, 0, 2'd1, 0, 8'h33, "R5");
    ticks(3, "R5");
    rd_all("R5");
    cyc(1, 1, 0, 2'd0, 0, 8'h80, "R5");
    cyc(1, 1, 0, 2'd1, 0, 8'h44, "R5");
    ticks(3, "R5");
    rd_all("R5");
    // R10: low write equal to alarm
    wr_alm(24'h07_4455, "R10");
    cyc(0, 1, 0, 2'd0, 0, 8'h55, "R10");
    // R12: halted with equal count, and medium/high rewrites give no pulse
    cyc(0, 1, 0, 2'd2, 0, 8'h07, "R12");
    ticks(8, "R12");
    cyc(0, 1, 0, 2'd1, 0, 8'h44, "R12");
    cyc(0, 1, 0, 2'd2, 0, 8'h07, "R12");
    ticks(4, "R12");
    rd_all("R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule